// File: doc/BRIEF.md
# Packed Integer Multiply-Accumulate Unit

This block is a SIMD integer datapath that multiplies two packed signed operands lane by lane and adds a packed accumulator. A 128-bit source vector is split into narrow lanes (16 bits by default) or lanes of twice that width, chosen per operation by an input pin. Four operation kinds are offered. The lane-wise kind keeps the source lane width. The two selective widening kinds use only the even-numbered or only the odd-numbered source lanes and return double-width results. The pair-sum kind adds two neighbouring products into one double-width result.

In the widening kinds the accumulator is packed densely at double width, so wide accumulator lane j sits beside wide result lane j. Each result lane either wraps modulo its own width or clamps to its signed range, chosen by a flag. Each accepted operation produces one registered result with a valid strobe one cycle later. The output holds its last value between operations.

Top module: `pmacUnit`

## Requirements
- R1: While reset is asserted and after its release, until the first accepted operation, `outValid` is 0 and `rOut` is all zeros.
- R2: `outValid` is 1 exactly in the cycle after a cycle with `inValid` = 1; when `inValid` is 0, `rOut` keeps its previous value.
- R3: With `opSel` = 0 (lane-wise), result lane i in bits [i*W +: W] equals the signed product a[i]*b[i] plus signed c[i], where W is the source lane width.
- R4: With `opSel` = 1 (even widening), wide result lane j in bits [j*2W +: 2W] equals a[2j]*b[2j] plus the signed 2W-bit accumulator lane c in bits [j*2W +: 2W].
- R5: With `opSel` = 2 (odd widening), wide result lane j equals a[2j+1]*b[2j+1] plus wide accumulator lane j.
- R6: With `opSel` = 3 (pair sum), wide result lane j equals a[2j]*b[2j] + a[2j+1]*b[2j+1] plus wide accumulator lane j.
- R7: With `satEn` = 1, a lane whose exact sum is above the signed maximum of its result width gives that maximum, and one below the signed minimum gives that minimum.
- R8: With `satEn` = 0, each result lane is the exact sum modulo 2 to the power of its result width.
- R9: `wide32` = 0 selects source lanes of LANE_W bits (16 by default); `wide32` = 1 selects source lanes of 2*LANE_W bits.
- R10: Lanes are independent: an overflow, a wrap or a clamp in one lane leaves every other lane unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and controls are valid this cycle |
| wide32 | input | 1 | 0: LANE_W-bit source lanes, 1: 2*LANE_W-bit source lanes |
| opSel | input | 2 | 0 lane-wise, 1 even widening, 2 odd widening, 3 pair sum |
| satEn | input | 1 | 1: clamp each lane, 0: wrap |
| aIn | input | VEC_W | First multiplicand vector |
| bIn | input | VEC_W | Second multiplicand vector |
| cIn | input | VEC_W | Accumulator vector, packed at the result lane width |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| rOut | output | VEC_W | Packed result |

## Verification
The assertions assume that `inValid`, `opSel`, `wide32`, `satEn` and the operands are driven to known values in every cycle out of reset. They also assume that an operand of all zeros makes every product zero, so the accumulator passes through unchanged in every mode. The stimulus only changes inputs on the falling clock edge. It drives `inValid` low whenever it is idle and mixes zero operands, extreme values and arbitrary values. This keeps every clocked property inside the conditions it was written for.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

  typedef enum logic [1:0] {
    OP_LANE = 2'd0,
    OP_EVEN = 2'd1,
    OP_ODD  = 2'd2,
    OP_PAIR = 2'd3
  } macOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic wideLanes;
    logic plain;
    logic useEven;
    logic useOdd;
    logic sat;
  } macStrobe_t;

endpackage

// File: rtl/pmacLaneSet.sv
module pmacLaneSet #(
  parameter int VEC_W = 128,
  parameter int W     = 16
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [VEC_W-1:0] c,
  input  logic             plain,
  input  logic             useEven,
  input  logic             useOdd,
  input  logic             sat,
  output logic [VEC_W-1:0] res
);
  localparam int NL = VEC_W / W;
  localparam int NP = NL / 2;
  localparam int PW = 2 * W;
  localparam int SW = 2 * W + 2;

  localparam logic signed [SW-1:0] NMAX = {{(SW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [SW-1:0] NMIN = {{(SW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [SW-1:0] WMAX = {{(SW-PW+1){1'b0}}, {(PW-1){1'b1}}};
  localparam logic signed [SW-1:0] WMIN = {{(SW-PW+1){1'b1}}, {(PW-1){1'b0}}};

  function automatic logic [W-1:0] fitNarrow(input logic signed [SW-1:0] v, input logic s);
    if (s && (v > NMAX)) return NMAX[W-1:0];
    if (s && (v < NMIN)) return NMIN[W-1:0];
    return v[W-1:0];
  endfunction

  function automatic logic [PW-1:0] fitWide(input logic signed [SW-1:0] v, input logic s);
    if (s && (v > WMAX)) return WMAX[PW-1:0];
    if (s && (v < WMIN)) return WMIN[PW-1:0];
    return v[PW-1:0];
  endfunction

  logic signed [PW-1:0] prod [NL];
  logic [VEC_W-1:0] plainRes;
  logic [VEC_W-1:0] wideRes;

  // one signed multiplier per source lane, shared by every mode
  for (genvar i = 0; i < NL; i++) begin : g_mul
    logic signed [PW-1:0] opA;
    logic signed [PW-1:0] opB;
    assign opA = PW'($signed(a[i*W +: W]));
    assign opB = PW'($signed(b[i*W +: W]));
    assign prod[i] = opA * opB;
  end

  for (genvar i = 0; i < NL; i++) begin : g_plain
    logic signed [SW-1:0] sum;
    assign sum = SW'(prod[i]) + SW'($signed(c[i*W +: W]));
    assign plainRes[i*W +: W] = fitNarrow(sum, sat);
  end

  for (genvar j = 0; j < NP; j++) begin : g_wide
    logic signed [PW-1:0] termE;
    logic signed [PW-1:0] termO;
    logic signed [SW-1:0] sum;
    assign termE = useEven ? prod[2*j]   : '0;
    assign termO = useOdd  ? prod[2*j+1] : '0;
    assign sum   = SW'(termE) + SW'(termO) + SW'($signed(c[j*PW +: PW]));
    assign wideRes[j*PW +: PW] = fitWide(sum, sat);
  end

  assign res = plain ? plainRes : wideRes;

endmodule

// File: rtl/pmacDatapath.sv
module pmacDatapath
  import pmac_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  macStrobe_t       strobe,
  input  logic [VEC_W-1:0] aIn,
  input  logic [VEC_W-1:0] bIn,
  input  logic [VEC_W-1:0] cIn,
  output logic [VEC_W-1:0] rOut
);
  logic [VEC_W-1:0] setRes [2];
  logic [VEC_W-1:0] nextRes;

  // variant 0: LANE_W lanes, variant 1: 2*LANE_W lanes
  for (genvar gv = 0; gv < 2; gv++) begin : g_width
    pmacLaneSet #(
      .VEC_W (VEC_W),
      .W     (LANE_W << gv)
    ) u_set (
      .a       (aIn),
      .b       (bIn),
      .c       (cIn),
      .plain   (strobe.plain),
      .useEven (strobe.useEven),
      .useOdd  (strobe.useOdd),
      .sat     (strobe.sat),
      .res     (setRes[gv])
    );
  end

  assign nextRes = strobe.wideLanes ? setRes[1] : setRes[0];

  always_ff @(posedge clk) begin
    if (!rstN)            rOut <= '0;
    else if (strobe.load) rOut <= nextRes;
  end

endmodule

// File: rtl/pmacControl.sv
module pmacControl
  import pmac_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       wide32,
  input  logic [1:0] opSel,
  input  logic       satEn,
  output macStrobe_t strobe,
  output logic       outValid
);
  macOp_e op;
  assign op = macOp_e'(opSel);

  always_comb begin
    strobe.load      = inValid;
    strobe.wideLanes = wide32;
    strobe.plain     = (op == OP_LANE);
    strobe.useEven   = (op == OP_EVEN) || (op == OP_PAIR);
    strobe.useOdd    = (op == OP_ODD)  || (op == OP_PAIR);
    strobe.sat       = satEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/pmacUnit.sv
module pmacUnit
  import pmac_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             wide32,
  input  logic [1:0]       opSel,
  input  logic             satEn,
  input  logic [VEC_W-1:0] aIn,
  input  logic [VEC_W-1:0] bIn,
  input  logic [VEC_W-1:0] cIn,
  output logic             outValid,
  output logic [VEC_W-1:0] rOut
);
  macStrobe_t strobe;

  pmacControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .wide32   (wide32),
    .opSel    (opSel),
    .satEn    (satEn),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pmacDatapath #(
    .VEC_W  (VEC_W),
    .LANE_W (LANE_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .aIn    (aIn),
    .bIn    (bIn),
    .cIn    (cIn),
    .rOut   (rOut)
  );

endmodule

// File: rtl/pmacChecker.sv
module pmacChecker #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [VEC_W-1:0] aIn,
  input logic [VEC_W-1:0] bIn,
  input logic [VEC_W-1:0] cIn,
  input logic [1:0]       opSel,
  input logic             plainS,
  input logic             evenS,
  input logic             oddS,
  input logic             outValid,
  input logic [VEC_W-1:0] rOut
);

  // R2
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(rOut));

  // R3
  zero_mult_lane_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == 2'd0 && bIn == '0) |=> (rOut == $past(cIn)));

  // R4
  zero_mult_any_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && aIn == '0) |=> (rOut == $past(cIn)));

  // R6
  strobe_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (plainS != (evenS || oddS)));

endmodule

bind pmacUnit pmacChecker #(.VEC_W(VEC_W)) u_pmacChecker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .aIn      (aIn),
  .bIn      (bIn),
  .cIn      (cIn),
  .opSel    (opSel),
  .plainS   (strobe.plain),
  .evenS    (strobe.useEven),
  .oddS     (strobe.useOdd),
  .outValid (outValid),
  .rOut     (rOut)
);

// File: tb/test_pmacUnit.sv
module test_pmacUnit;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         wide32 = 1'b0;
  logic [1:0]   opSel = 2'd0;
  logic         satEn = 1'b0;
  logic [127:0] aIn = '0;
  logic [127:0] bIn = '0;
  logic [127:0] cIn = '0;
  logic         outValid;
  logic [127:0] rOut;

  int nChk = 0;
  int nFail = 0;
  logic [127:0] expQ [$];
  string        tagQ [$];
  logic [127:0] lastExp = '0;

  always #2 clk = ~clk;

  pmacUnit i_pmacUnit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wide32(wide32),
    .opSel(opSel), .satEn(satEn), .aIn(aIn), .bIn(bIn), .cIn(cIn),
    .outValid(outValid), .rOut(rOut)
  );

  function automatic logic signed [127:0] laneOf(input logic [127:0] v, input int idx, input int w);
    logic signed [127:0] t;
    t = $signed(v >> (idx * w));
    t = t <<< (128 - w);
    t = t >>> (128 - w);
    return t;
  endfunction

  function automatic logic [127:0] model(input bit w32, input logic [1:0] md, input bit sat,
                                         input logic [127:0] a, input logic [127:0] b,
                                         input logic [127:0] c);
    int w;
    int t;
    logic signed [127:0] s, pe, po, hi, lo;
    logic [127:0] r, m;
    w = w32 ? 32 : 16;
    t = (md == 2'd0) ? w : 2 * w;
    r = '0;
    hi = (128'sd1 <<< (t - 1)) - 128'sd1;
    lo = -hi - 128'sd1;
    m  = (128'd1 << t) - 128'd1;
    for (int j = 0; j < 128 / t; j++) begin
      if (md == 2'd0) begin
        s = laneOf(a, j, w) * laneOf(b, j, w) + laneOf(c, j, w);
      end else begin
        pe = laneOf(a, 2*j, w) * laneOf(b, 2*j, w);
        po = laneOf(a, 2*j+1, w) * laneOf(b, 2*j+1, w);
        s  = laneOf(c, j, t) + ((md == 2'd1) ? pe : (md == 2'd2) ? po : pe + po);
      end
      if (sat && s > hi) s = hi;
      if (sat && s < lo) s = lo;
      r = r | ((s & m) << (j * t));
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic issue(input bit w32, input logic [1:0] md, input bit sat,
                       input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] c, input string tag);
    @(negedge clk);
    inValid = 1'b1; wide32 = w32; opSel = md; satEn = sat;
    aIn = a; bIn = b; cIn = c;
    expQ.push_back(model(w32, md, sat, a, b, c));
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      aIn = rnd128(); bIn = rnd128(); cIn = rnd128();
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2 unexpected outValid", {127'd0, outValid}, 128'd0);
        end else begin
          logic [127:0] e;
          string tg;
          e  = expQ.pop_front();
          tg = tagQ.pop_front();
          lastExp = e;
          check(rOut == e, tg, rOut, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  function automatic string modeTag(input logic [1:0] md);
    case (md)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    logic [127:0] a, b, c;
    // R1 during reset
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", {127'd0, outValid}, 128'd0);
    check(rOut == '0, "R1 rOut in reset", rOut, 128'd0);
    @(negedge clk);
    rstN = 1'b1;
    idle(2);
    check(outValid == 1'b0, "R1 outValid after reset", {127'd0, outValid}, 128'd0);
    check(rOut == '0, "R1 rOut after reset", rOut, 128'd0);

    // R3 R8 plain narrow, arbitrary
    for (int k = 0; k < 4; k++)
      issue(1'b0, 2'd0, k[0], rnd128(), rnd128(), rnd128(), "R3 plain narrow");
    // R7 positive clamp / R8 wrap
    a = {8{16'h7fff}};
    issue(1'b0, 2'd0, 1'b1, a, a, a, "R7 plain narrow clamp max");
    issue(1'b0, 2'd0, 1'b0, a, a, a, "R8 plain narrow wrap");
    // R7 negative clamp
    issue(1'b0, 2'd0, 1'b1, {8{16'h8000}}, {8{16'h7fff}}, {8{16'h8000}}, "R7 plain narrow clamp min");
    // R10 one lane overflows, neighbours small
    a = {{7{16'h0003}}, 16'h7fff};
    b = {{7{16'hfffe}}, 16'h7fff};
    c = {{7{16'h0005}}, 16'h1234};
    issue(1'b0, 2'd0, 1'b0, a, b, c, "R10 wrap isolation");
    issue(1'b0, 2'd0, 1'b1, a, b, c, "R10 clamp isolation");
    // R9 wide source lanes
    for (int k = 0; k < 3; k++)
      issue(1'b1, 2'd0, k[0], rnd128(), rnd128(), rnd128(), "R9 plain wide lanes");
    // widening modes both widths
    for (int md = 1; md < 4; md++)
      for (int k = 0; k < 4; k++)
        issue(k[1], 2'(md), k[0], rnd128(), rnd128(), rnd128(), modeTag(2'(md)));
    // R6 R7 extreme pair sum at wide lanes
    a = {4{32'h80000000}};
    c = {2{64'h7fffffffffffffff}};
    issue(1'b1, 2'd3, 1'b1, a, a, c, "R7 pair clamp max");
    issue(1'b1, 2'd3, 1'b0, a, a, c, "R8 pair wrap");
    issue(1'b0, 2'd3, 1'b1, {8{16'h8000}}, {8{16'h7fff}}, {4{32'h80000000}}, "R7 pair clamp min");
    issue(1'b0, 2'd1, 1'b1, {8{16'h7fff}}, {8{16'h7fff}}, {4{32'h7fff0000}}, "R4 even clamp");
    issue(1'b1, 2'd2, 1'b0, {4{32'h80000001}}, {4{32'h7fffffff}}, {2{64'h8000000000000000}}, "R5 odd wrap");
    // zero operands: accumulator passes
    c = rnd128();
    issue(1'b0, 2'd2, 1'b0, '0, rnd128(), c, "R5 zero operand");
    // back-to-back mixed
    for (int k = 0; k < 40; k++) begin
      logic [1:0] md;
      md = 2'($urandom_range(0, 3));
      issue(1'($urandom_range(0, 1)), md, 1'($urandom_range(0, 1)),
            rnd128(), rnd128(), rnd128(), modeTag(md));
    end
    idle(2);
    // R2 hold while idle
    idle(3);
    check(outValid == 1'b0, "R2 outValid idle", {127'd0, outValid}, 128'd0);
    check(rOut == lastExp, "R2 hold while idle", rOut, lastExp);
    check(expQ.size() == 0, "R2 all results delivered", 128'(expQ.size()), 128'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule